// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time entirely in packed BCD: a 7-bit sub-second count driven by a 128 Hz tick, then seconds, minutes, hours, day of week, day of month, month and a 16-bit century/year. Software reaches every field through a simple register port. Each access moves one byte, or a halfword for the year. Two control registers start and stop the count, hold the prescaler at zero while a new time is loaded, and apply a 30-second adjustment.

A carry flag is set on every seconds increment. Software clears it, reads the whole set of time fields, and then checks the flag again. If the flag was set during the read, the set may straddle a rollover and software reads it again. The flag can also drive an interrupt output when its enable bit is set. To load a new time, software first writes the control register with prescaler-reset set and start clear. It then writes the fields, and finally writes enable and start with prescaler-reset clear.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read as follows: sub-second 0, seconds, minutes, hours and weekday 0x00, day 0x01, month 0x01, year 0x2000, both control registers 0x00. `carry_irq` is low.
- R2: Register indices are 0 for sub-second, 1 for seconds, 2 for minutes, 3 for hours, 4 for weekday, 5 for day, 6 for month, 7 for year (century in bits 15:8, two-digit year in bits 7:0), 14 for control 1 and 15 for control 2. Any other index reads 0.
- R3: The sub-second register advances once per sampled `tick_128` while the clock runs. The 128th tick increments seconds and returns the sub-second count to 0.
- R4: Control 2 bit 3 is enable and bit 0 is start. Time advances only while both are 1. With either bit at 0, every field and the sub-second count hold their value.
- R5: Control 2 bit 1 is prescaler reset. While it is 1, the sub-second count is forced to 0 and time does not advance.
- R6: A write to indices 1 to 7 loads the field only while the clock is not running. The same write while running leaves the field unchanged.
- R7: Seconds and minutes wrap from 0x59 to 0x00 and hours from 0x23 to 0x00, each passing a carry to the next field. Within a field, the low digit wraps from 9 to the next tens value.
- R8: The day of month wraps to 0x01 after the last day of the month: 0x30 for months 4, 6, 9 and 11, 0x31 for the others, and February per R9. The month wraps from 0x12 to 0x01. The two-digit year carries into the century, and 0x9999 wraps to 0x0000.
- R9: February ends on 0x29 in a leap year and on 0x28 otherwise. A leap year is one divisible by 4. A year ending in 00 is a leap year only if its century is divisible by 4.
- R10: The weekday advances on every day change and wraps from 6 to 0.
- R11: Control 1 bit 7 is the carry flag. It is set on every seconds increment. Writing 0 to it clears it and writing 1 leaves it unchanged. A seconds increment in the same cycle as a clearing write leaves it set.
- R12: Control 1 bit 4 is the carry interrupt enable. `carry_irq` is high exactly when the carry flag and this enable are both 1.
- R13: Writing 1 to control 2 bit 2 sets seconds to 0x00. If seconds were 0x30 or more, minutes increment, carrying onward as in R7. Bit 2 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_128 | input | 1 | One-cycle pulse at 128 Hz |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register index for read and write |
| bus_wdata | input | 16 | Write data (bits 7:0 except for the year) |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The hardest situations to reach from the ports are the deep carry chains, such as the end of a leap February, a century boundary or the wrap of 9999. Waiting for them would take years of ticks. The bench therefore uses the stop, load and start sequence to place the calendar one second before each boundary. It then pulses the tick on 128 consecutive cycles and reads back every field. The 30-second adjustment is reached the same way, from loaded seconds values just below and just above 0x30, including a case where the minute carry ripples into the hour.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] IDX_SUB  = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_SEC  = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_HOUR = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_WDAY = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_DAY  = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_MON  = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_YEAR = 4'd7;
  localparam logic [ADDR_W-1:0] IDX_CTL1 = 4'd14;
  localparam logic [ADDR_W-1:0] IDX_CTL2 = 4'd15;

  localparam int C1_CARRY = 7;
  localparam int C1_CIE   = 4;
  localparam int C2_EN    = 3;
  localparam int C2_ADJ   = 2;
  localparam int C2_PRST  = 1;
  localparam int C2_START = 0;

  // Increment a two-digit packed BCD byte (caller handles the field limit).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int bcd_val(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // Leap rule on a BCD century/year pair.
  function automatic logic is_leap(input logic [15:0] yr);
    int cen;
    int two;
    cen = bcd_val(yr[15:8]);
    two = bcd_val(yr[7:0]);
    if (two == 0) return (cen % 4) == 0;
    return (two % 4) == 0;
  endfunction

  // Last day of a BCD month, itself in BCD.
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int SUB_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold_zero,
  input  logic             tick,
  output logic [SUB_W-1:0] subsec,
  output logic             sec_tick
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  assign sec_tick = run && tick && (subsec == SUB_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)          subsec <= '0;
    else if (hold_zero)  subsec <= '0;
    else if (run && tick) subsec <= subsec + 1'b1;
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       c1_we,
  input  logic       c2_we,
  input  logic [7:0] wbyte,
  input  logic       sec_tick,
  output logic       carry_f,
  output logic       cie,
  output logic       en,
  output logic       prst,
  output logic       start,
  output logic       adj_pulse
);
  import rtc_core_pkg::*;

  assign adj_pulse = c2_we && wbyte[C2_ADJ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_f <= 1'b0;
      cie     <= 1'b0;
    end else if (c1_we) begin
      cie     <= wbyte[C1_CIE];
      carry_f <= sec_tick || (carry_f && wbyte[C1_CARRY]);
    end else if (sec_tick) begin
      carry_f <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      prst  <= 1'b0;
      start <= 1'b0;
    end else if (c2_we) begin
      en    <= wbyte[C2_EN];
      prst  <= wbyte[C2_PRST];
      start <= wbyte[C2_START];
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int WEEK_DAYS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        adj_pulse,
  input  logic        fld_we,
  input  logic [3:0]  fld_sel,
  input  logic [15:0] fld_data,
  output logic [7:0]  sec_f,
  output logic [7:0]  min_f,
  output logic [7:0]  hour_f,
  output logic [7:0]  wday_f,
  output logic [7:0]  day_f,
  output logic [7:0]  mon_f,
  output logic [15:0] year_f,
  output logic        day_step
);
  import rtc_core_pkg::*;

  localparam logic [7:0] WDAY_LAST = 8'(WEEK_DAYS - 1);

  logic [7:0]  sec_n, min_n, hour_n, wday_n, day_n, mon_n;
  logic [15:0] year_n;
  logic        c_min, c_hour, c_mon, c_yr, c_cen;

  always_comb begin
    sec_n  = sec_f;   min_n = min_f;  hour_n = hour_f;
    wday_n = wday_f;  day_n = day_f;  mon_n  = mon_f;  year_n = year_f;
    c_min = 1'b0; c_hour = 1'b0; day_step = 1'b0;
    c_mon = 1'b0; c_yr = 1'b0;  c_cen = 1'b0;

    if (adj_pulse) begin
      sec_n = 8'h00;
      c_min = (sec_f >= 8'h30);
    end else if (sec_tick) begin
      if (sec_f == 8'h59) begin sec_n = 8'h00; c_min = 1'b1; end
      else sec_n = bcd_inc(sec_f);
    end

    if (c_min) begin
      if (min_f == 8'h59) begin min_n = 8'h00; c_hour = 1'b1; end
      else min_n = bcd_inc(min_f);
    end
    if (c_hour) begin
      if (hour_f == 8'h23) begin hour_n = 8'h00; day_step = 1'b1; end
      else hour_n = bcd_inc(hour_f);
    end
    if (day_step) begin
      wday_n = (wday_f >= WDAY_LAST) ? 8'h00 : wday_f + 8'h01;
      if (day_f == last_day(mon_f, is_leap(year_f))) begin
        day_n = 8'h01; c_mon = 1'b1;
      end else day_n = bcd_inc(day_f);
    end
    if (c_mon) begin
      if (mon_f == 8'h12) begin mon_n = 8'h01; c_yr = 1'b1; end
      else mon_n = bcd_inc(mon_f);
    end
    if (c_yr) begin
      if (year_f[7:0] == 8'h99) begin year_n[7:0] = 8'h00; c_cen = 1'b1; end
      else year_n[7:0] = bcd_inc(year_f[7:0]);
    end
    if (c_cen) begin
      year_n[15:8] = (year_f[15:8] == 8'h99) ? 8'h00 : bcd_inc(year_f[15:8]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_f <= 8'h00; min_f <= 8'h00; hour_f <= 8'h00; wday_f <= 8'h00;
      day_f <= 8'h01; mon_f <= 8'h01; year_f <= 16'h2000;
    end else if (fld_we) begin
      case (fld_sel)
        IDX_SEC:  sec_f  <= fld_data[7:0];
        IDX_MIN:  min_f  <= fld_data[7:0];
        IDX_HOUR: hour_f <= fld_data[7:0];
        IDX_WDAY: wday_f <= fld_data[7:0];
        IDX_DAY:  day_f  <= fld_data[7:0];
        IDX_MON:  mon_f  <= fld_data[7:0];
        IDX_YEAR: year_f <= fld_data;
        default: ;
      endcase
    end else begin
      sec_f <= sec_n; min_f <= min_n; hour_f <= hour_n; wday_f <= wday_n;
      day_f <= day_n; mon_f <= mon_n; year_f <= year_n;
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int SUB_W     = 7,
  parameter int WEEK_DAYS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_128,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        carry_irq
);
  import rtc_core_pkg::*;

  localparam int SUB_PAD = DATA_W - SUB_W;

  logic [SUB_W-1:0] subsec;
  logic        sec_tick, run, fld_we, c1_we, c2_we, adj_pulse, day_step;
  logic        carry_f, cie, en, prst, start;
  logic [7:0]  sec_f, min_f, hour_f, wday_f, day_f, mon_f;
  logic [15:0] year_f;

  assign run    = en && start && !prst;
  assign c1_we  = bus_we && (bus_addr == IDX_CTL1);
  assign c2_we  = bus_we && (bus_addr == IDX_CTL2);
  assign fld_we = bus_we && !run && (bus_addr >= IDX_SEC) && (bus_addr <= IDX_YEAR);
  assign carry_irq = carry_f && cie;

  rtc_subsec #(.SUB_W(SUB_W)) u_subsec (
    .clk(clk), .rst_n(rst_n), .run(run), .hold_zero(prst),
    .tick(tick_128), .subsec(subsec), .sec_tick(sec_tick)
  );

  rtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .c1_we(c1_we), .c2_we(c2_we),
    .wbyte(bus_wdata[7:0]), .sec_tick(sec_tick),
    .carry_f(carry_f), .cie(cie), .en(en), .prst(prst), .start(start),
    .adj_pulse(adj_pulse)
  );

  rtc_calendar #(.WEEK_DAYS(WEEK_DAYS)) u_cal (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .adj_pulse(adj_pulse),
    .fld_we(fld_we), .fld_sel(bus_addr), .fld_data(bus_wdata),
    .sec_f(sec_f), .min_f(min_f), .hour_f(hour_f), .wday_f(wday_f),
    .day_f(day_f), .mon_f(mon_f), .year_f(year_f), .day_step(day_step)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_SUB:  bus_rdata = {{SUB_PAD{1'b0}}, subsec};
      IDX_SEC:  bus_rdata = {8'h00, sec_f};
      IDX_MIN:  bus_rdata = {8'h00, min_f};
      IDX_HOUR: bus_rdata = {8'h00, hour_f};
      IDX_WDAY: bus_rdata = {8'h00, wday_f};
      IDX_DAY:  bus_rdata = {8'h00, day_f};
      IDX_MON:  bus_rdata = {8'h00, mon_f};
      IDX_YEAR: bus_rdata = year_f;
      IDX_CTL1: begin
        bus_rdata[C1_CARRY] = carry_f;
        bus_rdata[C1_CIE]   = cie;
      end
      IDX_CTL2: begin
        bus_rdata[C2_EN]    = en;
        bus_rdata[C2_PRST]  = prst;
        bus_rdata[C2_START] = start;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker #(
  parameter int SUB_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             run,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [15:0]      bus_rdata,
  input logic [SUB_W-1:0] subsec,
  input logic             carry_f,
  input logic             day_step,
  input logic [7:0]       sec_f,
  input logic [7:0]       min_f,
  input logic [7:0]       hour_f,
  input logic [7:0]       wday_f,
  input logic [7:0]       mon_f
);
  AST_SUBSEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (subsec == '0)); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_we) |=> ($stable(sec_f) && $stable(min_f) && $stable(hour_f))); // R4
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_f <= 8'h23) && (min_f <= 8'h59)); // R7
  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_f >= 8'h01) && (mon_f <= 8'h12)); // R8
  AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !bus_we) |=> !$stable(wday_f) && (wday_f <= 8'h06)); // R10
  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> carry_f); // R11
  AST_ADJ_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'd15) |-> (bus_rdata[2] == 1'b0)); // R13
endmodule

bind bcd_rtc_core rtc_core_checker #(.SUB_W(SUB_W)) u_rtc_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .run(run),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .subsec(subsec), .carry_f(carry_f), .day_step(day_step),
  .sec_f(sec_f), .min_f(min_f), .hour_f(hour_f), .wday_f(wday_f),
  .mon_f(mon_f)
);

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {year, month, day, weekday, hour, minute, second} loaded, then expected after one second
  localparam logic [127:0] VECS [NVEC] = '{
    {16'h2024,8'h01,8'h15,8'h02,8'h12,8'h34,8'h56, 16'h2024,8'h01,8'h15,8'h02,8'h12,8'h34,8'h57},
    {16'h2024,8'h02,8'h28,8'h03,8'h23,8'h59,8'h59, 16'h2024,8'h02,8'h29,8'h04,8'h00,8'h00,8'h00},
    {16'h2023,8'h02,8'h28,8'h06,8'h23,8'h59,8'h59, 16'h2023,8'h03,8'h01,8'h00,8'h00,8'h00,8'h00},
    {16'h2100,8'h02,8'h28,8'h00,8'h23,8'h59,8'h59, 16'h2100,8'h03,8'h01,8'h01,8'h00,8'h00,8'h00},
    {16'h2000,8'h02,8'h28,8'h01,8'h23,8'h59,8'h59, 16'h2000,8'h02,8'h29,8'h02,8'h00,8'h00,8'h00},
    {16'h2099,8'h12,8'h31,8'h05,8'h23,8'h59,8'h59, 16'h2100,8'h01,8'h01,8'h06,8'h00,8'h00,8'h00},
    {16'h2024,8'h04,8'h30,8'h02,8'h23,8'h59,8'h59, 16'h2024,8'h05,8'h01,8'h03,8'h00,8'h00,8'h00},
    {16'h1999,8'h09,8'h09,8'h01,8'h09,8'h59,8'h59, 16'h1999,8'h09,8'h09,8'h01,8'h10,8'h00,8'h00},
    {16'h9999,8'h12,8'h31,8'h06,8'h23,8'h59,8'h59, 16'h0000,8'h01,8'h01,8'h00,8'h00,8'h00,8'h00},
    {16'h2025,8'h01,8'h31,8'h04,8'h23,8'h59,8'h59, 16'h2025,8'h02,8'h01,8'h05,8'h00,8'h00,8'h00},
    {16'h2024,8'h02,8'h29,8'h04,8'h23,8'h59,8'h59, 16'h2024,8'h03,8'h01,8'h05,8'h00,8'h00,8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_128 = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        carry_irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;
  bit done = 1'b0;

  bcd_rtc_core i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_128(tick_128), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .carry_irq(carry_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    bus_addr = a;
    #1 rv = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_128 = 1'b1;
    end
    @(negedge clk);
    tick_128 = 1'b0;
  endtask

  task automatic load(input logic [63:0] t);
    wr(4'd15, 16'h0002);
    wr(4'd1, {8'h00, t[7:0]});
    wr(4'd2, {8'h00, t[15:8]});
    wr(4'd3, {8'h00, t[23:16]});
    wr(4'd4, {8'h00, t[31:24]});
    wr(4'd5, {8'h00, t[39:32]});
    wr(4'd6, {8'h00, t[47:40]});
    wr(4'd7, t[63:48]);
    wr(4'd15, 16'h0009);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0);  check("R1 subsec", rv, 16'h0000);
    rd(4'd1);  check("R1 sec", rv, 16'h0000);
    rd(4'd5);  check("R1 day", rv, 16'h0001);
    rd(4'd6);  check("R1 month", rv, 16'h0001);
    rd(4'd7);  check("R1 year", rv, 16'h2000);
    rd(4'd14); check("R1 ctl1", rv, 16'h0000);
    rd(4'd15); check("R1 ctl2", rv, 16'h0000);
    check("R1 irq", {15'd0, carry_irq}, 16'h0000);

    // R7 R8 R9 R10 rollover table
    for (int v = 0; v < NVEC; v++) begin
      logic [63:0] ex;
      ex = VECS[v][63:0];
      load(VECS[v][127:64]);
      ticks(128);
      rd(4'd1); check("R7 sec", rv, {8'h00, ex[7:0]});
      rd(4'd2); check("R7 min", rv, {8'h00, ex[15:8]});
      rd(4'd3); check("R7 hour", rv, {8'h00, ex[23:16]});
      rd(4'd4); check("R10 wday", rv, {8'h00, ex[31:24]});
      rd(4'd5); check("R8/R9 day", rv, {8'h00, ex[39:32]});
      rd(4'd6); check("R8 month", rv, {8'h00, ex[47:40]});
      rd(4'd7); check("R8 year", rv, ex[63:48]);
    end

    // R3 sub-second count and wrap
    load({16'h2024, 8'h06, 8'h10, 8'h01, 8'h10, 8'h20, 8'h30});
    wr(4'd14, 16'h0000);
    ticks(5);
    rd(4'd0); check("R3 subsec5", rv, 16'h0005);
    rd(4'd1); check("R3 sec held", rv, 16'h0030);
    ticks(123);
    rd(4'd0); check("R3 subsec wrap", rv, 16'h0000);
    rd(4'd1); check("R3 sec inc", rv, 16'h0031);

    // R11 carry flag
    rd(4'd14); check("R11 cf set", rv, 16'h0080);
    wr(4'd14, 16'h0080);
    rd(4'd14); check("R11 write1 keeps", rv, 16'h0080);
    wr(4'd14, 16'h0000);
    rd(4'd14); check("R11 write0 clears", rv, 16'h0000);

    // R12 interrupt
    wr(4'd14, 16'h0010);
    check("R12 irq off", {15'd0, carry_irq}, 16'h0000);
    ticks(128);
    check("R12 irq on", {15'd0, carry_irq}, 16'h0001);
    rd(4'd14); check("R12 ctl1", rv, 16'h0090);
    wr(4'd14, 16'h0010);
    check("R12 irq cleared", {15'd0, carry_irq}, 16'h0000);

    // R4 enable and start gate counting
    ticks(3);
    wr(4'd15, 16'h0001);
    ticks(200);
    rd(4'd0); check("R4 no enable subsec", rv, 16'h0003);
    rd(4'd1); check("R4 no enable sec", rv, 16'h0032);
    wr(4'd15, 16'h0008);
    ticks(200);
    rd(4'd0); check("R4 no start subsec", rv, 16'h0003);
    rd(4'd1); check("R4 no start sec", rv, 16'h0032);

    // R5 prescaler reset
    wr(4'd15, 16'h000B);
    rd(4'd0); check("R5 subsec zero", rv, 16'h0000);
    ticks(200);
    rd(4'd0); check("R5 subsec held", rv, 16'h0000);
    rd(4'd1); check("R5 sec held", rv, 16'h0032);

    // R6 write while running ignored
    wr(4'd15, 16'h0009);
    wr(4'd1, 16'h0045);
    rd(4'd1); check("R6 running write ignored", rv, 16'h0032);

    // R13 thirty-second adjust
    load({16'h2024, 8'h06, 8'h10, 8'h01, 8'h05, 8'h10, 8'h35});
    wr(4'd15, 16'h000D);
    rd(4'd1); check("R13 sec zero", rv, 16'h0000);
    rd(4'd2); check("R13 min inc", rv, 16'h0011);
    rd(4'd15); check("R13 adj reads 0", rv, 16'h0009);
    load({16'h2024, 8'h06, 8'h10, 8'h01, 8'h05, 8'h10, 8'h29});
    wr(4'd15, 16'h000D);
    rd(4'd1); check("R13 sec zero low", rv, 16'h0000);
    rd(4'd2); check("R13 min kept", rv, 16'h0010);
    load({16'h2024, 8'h06, 8'h10, 8'h01, 8'h07, 8'h59, 8'h40});
    wr(4'd15, 16'h000D);
    rd(4'd2); check("R13 min wrap", rv, 16'h0000);
    rd(4'd3); check("R13 hour carry", rv, 16'h0008);

    // R2 unmapped index
    rd(4'd9); check("R2 unmapped", rv, 16'h0000);
    rd(4'd7); check("R2 year index", rv, 16'h2024);

    finish_run();
  end
endmodule